// File: doc/BRIEF.md
# Port Control Register Block with Error-Insert Strobe

This block holds the two 16-bit control words of one transceiver port on a plain register bus: address, write enable, write data and combinational read data. It turns their fields into control outputs for the rest of the port: the power-down and clock-enable levels, a data-path reset, a full port reset, transmit line gating and a driver tri-state request. The data path, the error generators and the analog line driver sit outside this block. Only their control signals come from here.

A one-cycle error-insert strobe is derived from a rising edge of a selectable source. That source is either a software bit in the first word or a chip-wide insert input. A software full-reset bit is combined with the active-low hardware reset and a chip-wide reset input. The combined reset returns every other register bit to its default. The full-reset bit keeps its own value, so software can clear it again.

Top module: `port_ctl_regs`

## Requirements
- R1: After the hardware reset, the word at address 0x41 reads 0x0006 (power-down bit 2 = 1, data-path reset bit 1 = 1), the word at 0x42 reads 0x0000, and every other address reads 0x0000.
- R2: At 0x41 only bits 7 (insert bit), 6 (insert source select), 2, 1 and 0 hold written values. At 0x42 only bits 15 (line enable), 14 (tri-state), 13, 12, 10:8 and 5:3 do. All other bits read 0 and ignore writes.
- R3: With bit 6 of 0x41 at 0, a 0-to-1 change of bit 7 produces exactly one high cycle on err_ins_o. The pulse comes in the cycle after the first clock edge that follows the write. Holding bit 7 high gives no further pulse.
- R4: With bit 6 of 0x41 at 1, the strobe follows rising edges of glb_err_i instead. glb_err_i high at an edge where it was low at the edge before gives err_ins_o high for the following cycle. Bit 7 then has no effect.
- R5: While bit 0 of 0x41 is 1, every other bit of both words is held at its R1 default and writes to them are ignored. The strobe logic is cleared. Bit 0 still accepts writes.
- R6: port_rst_o is the OR of bit 0 of 0x41, the inverted rst_ni and glb_rst_i. glb_rst_i also holds the registers at their defaults, like R5. Only rst_ni clears bit 0.
- R7: dp_rst_o is high when bit 1 of 0x41 is 1 or port_rst_o is high.
- R8: pwr_dn_o equals bit 2 of 0x41 and clk_en_o is its inverse.
- R9: tx_clk_o and tx_dat_o follow tx_clk_i and tx_dat_i when bit 15 of 0x42 is 1, and are forced low when it is 0.
- R10: tx_hiz_o is high only when bit 14 of 0x42 is 1 and bit 2 of 0x41 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| glb_rst_i | input | 1 | Chip-wide reset request, synchronous |
| glb_err_i | input | 1 | Chip-wide error-insert source |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| err_ins_o | output | 1 | One-cycle error-insert strobe |
| port_rst_o | output | 1 | Effective full port reset |
| dp_rst_o | output | 1 | Data-path reset |
| pwr_dn_o | output | 1 | Port powered down |
| clk_en_o | output | 1 | Port clock enable |
| tx_clk_i | input | 1 | Transmit clock from the data path |
| tx_dat_i | input | 1 | Transmit data from the data path |
| tx_clk_o | output | 1 | Gated transmit clock to the line |
| tx_dat_o | output | 1 | Gated transmit data to the line |
| tx_hiz_o | output | 1 | Line driver tri-state request |

## Verification
The strobe is tried in four ways. The software bit is raised and held for many cycles, which exposes level-triggered behaviour. It is raised, dropped and raised again, which shows that each fresh edge re-arms the detector. The chip-wide input is driven as a single-cycle blip, as a long level and as a toggle on every cycle, which separates true edge detection from pulse stretching or missed back-to-back edges. The software bit is toggled while the chip-wide source is selected, which shows that source selection really excludes it. Random bus writes mixed with soft, chip-wide and hardware resets compare every output against a behavioural model on each clock.

// File: rtl/port_ctl_pkg.sv
package port_ctl_pkg;
  localparam int unsigned DW = 16;

  localparam int unsigned B_INS  = 7;
  localparam int unsigned B_SEL  = 6;
  localparam int unsigned B_PD   = 2;
  localparam int unsigned B_DPR  = 1;
  localparam int unsigned B_RST  = 0;
  localparam int unsigned B_LEN  = 15;
  localparam int unsigned B_HIZ  = 14;

  // bit 0 of word 1 lives in its own flop, excluded here
  localparam logic [DW-1:0] W1_MASK = 16'h00C6;
  localparam logic [DW-1:0] W1_DEF  = 16'h0006;
  localparam logic [DW-1:0] W2_MASK = 16'hF738;
  localparam logic [DW-1:0] W2_DEF  = 16'h0000;
endpackage

// File: rtl/ctl_word_reg.sv
module ctl_word_reg #(
  parameter int unsigned     W       = 16,
  parameter logic [W-1:0]    RST_VAL = '0,
  parameter logic [W-1:0]    WR_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= RST_VAL;
    else if (clr_i)  q <= RST_VAL;
    else if (we_i)   q <= (d_i & WR_MASK) | (q & ~WR_MASK);
  end

  assign q_o = q;
endmodule

// File: rtl/edge_pulse.sv
module edge_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic src_i,
  output logic pulse_o
);
  logic prev_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else if (clr_i) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= src_i;
      pulse_q <= src_i & ~prev_q;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/line_ctl.sv
module line_ctl #(
  parameter int unsigned N = 2
) (
  input  logic         en_i,
  input  logic         hiz_req_i,
  input  logic         pd_i,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] sig_o,
  output logic         hiz_o
);
  for (genvar g = 0; g < N; g++) begin : g_gate
    assign sig_o[g] = sig_i[g] & en_i;
  end
  // tri-state only meaningful while the driver is powered
  assign hiz_o = hiz_req_i & ~pd_i;
endmodule

// File: rtl/port_ctl_regs.sv
module port_ctl_regs
  import port_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] W1_ADR = 8'h41,
  parameter logic [ADDR_W-1:0] W2_ADR = 8'h42
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              glb_rst_i,
  input  logic              glb_err_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_ins_o,
  output logic              port_rst_o,
  output logic              dp_rst_o,
  output logic              pwr_dn_o,
  output logic              clk_en_o,
  input  logic              tx_clk_i,
  input  logic              tx_dat_i,
  output logic              tx_clk_o,
  output logic              tx_dat_o,
  output logic              tx_hiz_o
);
  logic          we1, we2, sw_rst, sync_rst;
  logic [DW-1:0] w1_q, w2_q;
  logic [0:0]    rst_q;
  logic          ins_src;
  logic [1:0]    tx_in, tx_out;

  assign we1 = we_i && (addr_i == W1_ADR);
  assign we2 = we_i && (addr_i == W2_ADR);

  // self-excluding reset bit: only the hardware pin clears it
  ctl_word_reg #(.W(1), .RST_VAL(1'b0), .WR_MASK(1'b1)) u_rst (
    .clk_i, .rst_ni, .clr_i(1'b0), .we_i(we1),
    .d_i(wdata_i[B_RST]), .q_o(rst_q)
  );

  assign sw_rst   = rst_q[0];
  assign sync_rst = sw_rst | glb_rst_i;

  ctl_word_reg #(.W(DW), .RST_VAL(W1_DEF), .WR_MASK(W1_MASK)) u_w1 (
    .clk_i, .rst_ni, .clr_i(sync_rst), .we_i(we1), .d_i(wdata_i), .q_o(w1_q)
  );

  ctl_word_reg #(.W(DW), .RST_VAL(W2_DEF), .WR_MASK(W2_MASK)) u_w2 (
    .clk_i, .rst_ni, .clr_i(sync_rst), .we_i(we2), .d_i(wdata_i), .q_o(w2_q)
  );

  assign ins_src = w1_q[B_SEL] ? glb_err_i : w1_q[B_INS];

  edge_pulse u_edge (
    .clk_i, .rst_ni, .clr_i(sync_rst), .src_i(ins_src), .pulse_o(err_ins_o)
  );

  assign tx_in = {tx_dat_i, tx_clk_i};

  line_ctl #(.N(2)) u_line (
    .en_i(w2_q[B_LEN]), .hiz_req_i(w2_q[B_HIZ]), .pd_i(w1_q[B_PD]),
    .sig_i(tx_in), .sig_o(tx_out), .hiz_o(tx_hiz_o)
  );

  assign tx_clk_o = tx_out[0];
  assign tx_dat_o = tx_out[1];

  assign port_rst_o = sync_rst | ~rst_ni;
  assign dp_rst_o   = w1_q[B_DPR] | port_rst_o;
  assign pwr_dn_o   = w1_q[B_PD];
  assign clk_en_o   = ~w1_q[B_PD];

  always_comb begin
    rdata_o = '0;
    if (addr_i == W1_ADR)      rdata_o = {w1_q[DW-1:1], sw_rst};
    else if (addr_i == W2_ADR) rdata_o = w2_q;
  end
endmodule

// File: rtl/port_ctl_chk.sv
module port_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic err_ins_o,
  input logic port_rst_o,
  input logic dp_rst_o,
  input logic pwr_dn_o,
  input logic clk_en_o,
  input logic tx_clk_i,
  input logic tx_dat_i,
  input logic tx_clk_o,
  input logic tx_dat_o,
  input logic tx_hiz_o
);
  // R3
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ins_o |=> !err_ins_o);
  // R5
  rst_holds_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_rst_o |=> pwr_dn_o);
  // R7
  dp_covers_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_rst_o |-> dp_rst_o);
  // R8
  clk_en_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_o != clk_en_o);
  // R9
  tx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_clk_o |-> tx_clk_i) and (tx_dat_o |-> tx_dat_i));
  // R10
  hiz_powered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_hiz_o |-> !pwr_dn_o);
endmodule

bind port_ctl_regs port_ctl_chk chk_i (.*);

// File: tb/port_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module port_ctl_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_rst = 1'b0, glb_err = 1'b0, we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [15:0] wdata = 16'h0000;
  logic txc = 1'b0, txd = 1'b0;
  logic [15:0] rdata;
  logic ins, prst, dprst, pd, cen, txc_o, txd_o, hiz;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  port_ctl_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .glb_rst_i(glb_rst), .glb_err_i(glb_err),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
    .err_ins_o(ins), .port_rst_o(prst), .dp_rst_o(dprst), .pwr_dn_o(pd),
    .clk_en_o(cen), .tx_clk_i(txc), .tx_dat_i(txd), .tx_clk_o(txc_o),
    .tx_dat_o(txd_o), .tx_hiz_o(hiz)
  );

  // behavioural model
  logic [15:0] m_a = 16'h0006, m_b = 16'h0000;
  bit m_rst = 0, m_last = 0, m_pulse = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 16'h0006; m_b = 0; m_rst = 0; m_last = 0; m_pulse = 0;
    end else begin
      bit hold, src, new_rst;
      hold = m_rst || glb_rst;
      src  = m_a[6] ? glb_err : m_a[7];
      new_rst = (we && addr == 8'h41) ? wdata[0] : m_rst;
      if (hold) begin
        m_a = 16'h0006; m_b = 0; m_last = 0; m_pulse = 0;
      end else begin
        m_pulse = src && !m_last;
        m_last  = src;
        if (we && addr == 8'h41) m_a = (wdata & 16'h00C6) | (m_a & ~16'h00C6);
        if (we && addr == 8'h42) m_b = wdata & 16'hF738;
      end
      m_rst = new_rst;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [15:0] er;
    bit ep;
    er = (addr == 8'h41) ? {m_a[15:1], m_rst} : (addr == 8'h42) ? m_b : 16'h0;
    ep = m_rst || !rst_n || glb_rst;
    chk(m_rst ? "R5 rdata" : "R2 rdata", rdata, er);
    chk(m_a[6] ? "R4 err_ins_o" : "R3 err_ins_o", 16'(ins), 16'(m_pulse));
    chk("R6 port_rst_o", 16'(prst), 16'(ep));
    chk("R7 dp_rst_o", 16'(dprst), 16'(m_a[1] || ep));
    chk("R8 pwr_dn_o", {15'h0, pd}, {15'h0, m_a[2]});
    chk("R8 clk_en_o", {15'h0, cen}, {15'h0, !m_a[2]});
    chk("R9 tx_clk_o", 16'(txc_o), 16'(txc && m_b[15]));
    chk("R9 tx_dat_o", 16'(txd_o), 16'(txd && m_b[15]));
    chk("R10 tx_hiz_o", 16'(hiz), 16'(m_b[14] && !m_a[2]));
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    addr = a;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    rd(8'h41); chk("R1 word1 default", rdata, 16'h0006);
    rd(8'h42); chk("R1 word2 default", rdata, 16'h0000);
    rd(8'h40); chk("R1 unmapped", rdata, 16'h0000);
    // R2 masks
    wr(8'h42, 16'hFFFF); rd(8'h42); chk("R2 word2 mask", rdata, 16'hF738);
    wr(8'h41, 16'hFF3E); rd(8'h41); chk("R2 word1 mask", rdata, 16'h0006);
    wr(8'h40, 16'hFFFF); rd(8'h40);
    // R9 gating, R10 tri-state
    for (int i = 0; i < 12; i++) begin txc = i[0]; txd = i[1]; step(); end
    wr(8'h42, 16'h4000);
    for (int i = 0; i < 6; i++) begin txc = i[0]; txd = i[2]; step(); end
    wr(8'h41, 16'h0000); step(2);
    wr(8'h42, 16'hC000); step(2);
    // R3 software edge: hold, drop, raise again
    wr(8'h41, 16'h0080); rd(8'h41); step(8);
    wr(8'h41, 16'h0000); step(2);
    wr(8'h41, 16'h0080); step(4);
    // R4 global source: blip, level, toggle, software bit ignored
    wr(8'h41, 16'h0040); step(2);
    glb_err = 1; step(); glb_err = 0; step(3);
    glb_err = 1; step(8); glb_err = 0; step(2);
    for (int i = 0; i < 10; i++) begin glb_err = ~glb_err; step(); end
    glb_err = 0;
    wr(8'h41, 16'h00C0); step(3); wr(8'h41, 16'h0040); wr(8'h41, 16'h00C0); step(3);
    // R5 soft reset
    wr(8'h42, 16'hF738);
    wr(8'h41, 16'h00C1); rd(8'h41); chk("R5 held default", rdata, 16'h0007);
    wr(8'h42, 16'hFFFF); rd(8'h42); chk("R5 write ignored", rdata, 16'h0000);
    glb_err = 1; step(3); glb_err = 0;
    wr(8'h41, 16'h0000); rd(8'h41); chk("R5 release", rdata, 16'h0006);
    // R6 global reset
    wr(8'h41, 16'h0040); wr(8'h42, 16'h8000);
    glb_rst = 1; step(); wr(8'h42, 16'hFFFF); glb_rst = 0;
    rd(8'h42); chk("R6 global clears", rdata, 16'h0000);
    // random traffic with occasional resets
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      addr = r[0] ? 8'h41 : (r[1] ? 8'h42 : 8'h43);
      wdata = r[31:16];
      if (addr == 8'h41 && r[7:4] != 0) wdata[0] = 1'b0;
      we = r[2];
      glb_err = r[3];
      glb_rst = (r[11:8] == 0);
      txc = r[12]; txd = r[13];
      if (r[14:8] == 7'h55) begin
        rst_n = 0; step(); rst_n = 1;
      end else step();
    end
    we = 0; glb_rst = 0;
    // R6 hardware reset clears the soft bit
    wr(8'h41, 16'h0001); rst_n = 0; step(); rst_n = 1; rd(8'h41);
    chk("R6 hw clears bit0", rdata, 16'h0006);
    step(2);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule